// File: doc/BRIEF.md
# Indirect configuration and I/O-port access bridge

This block sits between a host register port and a simplified downstream bus transaction interface. Software reaches configuration space, I/O-port space and a memory window indirectly. It first writes a 32-bit target into an address register. It then reads or writes one of three data windows. The window that is touched selects the downstream cycle type. The low two bits of the host offset, together with the access size, select the byte lanes.

A configuration target is laid out as bus number in bits 23:16, device/function in bits 15:8 and the register offset in bits 7:0. Configuration cycles always carry a dword-aligned address. An I/O cycle carries the 16-bit port number held in the low half of the address register. The bridge handles one downstream transaction at a time and holds the host's ready low until the downstream completion returns.

Before a configuration write, the bridge can issue a harmless guard read to the same target with its low byte cleared. This keeps a back-to-back address change from disturbing the write cycle. The guard read completes before the write is launched. When a configuration read ends in an abort because no device responded, the host sees all ones.

Top module: `cfgio_bridge`

## Requirements
- R1: A host write to offset 0x064 updates the 32-bit address register in the byte lanes it enables. A host read of 0x064 returns the register, with ready one cycle after the request is accepted and no downstream cycle.
- R2: An access in the configuration window (offsets 0x068 to 0x06B) launches one downstream cycle with command 0 (read) or 1 (write). Its address is the address register with bits 1:0 cleared.
- R3: An access in the I/O window (offsets 0x06C to 0x06F) launches command 2 (read) or 3 (write). Its address is the address register's bits 15:0, zero-extended.
- R4: An access in the memory window (offsets 0x070 to 0x073) launches command 4 (read) or 5 (write). Its address is the full 32-bit address register.
- R5: Downstream byte enables are active-high. Size code 0 (byte) sets only bit ofs[1:0]. Size code 1 (halfword) sets 4'b0011 when ofs[1]=0 and 4'b1100 when ofs[1]=1. Size codes 2 and 3 (word) set 4'b1111.
- R6: A configuration write is preceded by a guard cycle with command 0, the address register with bits 7:0 cleared, and all four byte enables. The write cycle starts only after the guard cycle has completed.
- R7: Only one downstream cycle is outstanding. While ds_valid is high without ds_done, the command, address and byte enables stay stable. h_ready is a single-cycle pulse. For a single-cycle window access it arrives exactly two cycles after the completion cycle's start, counted from the host's request (latency L gives L+2 cycles).
- R8: A configuration read that completes with ds_abort returns 32'hFFFFFFFF. Any other read completion, including an aborted I/O read, returns ds_rdata unchanged.
- R9: A write to an offset outside the four registers is ignored, and the address register is unchanged. A read there returns 0. Neither launches a downstream cycle.
- R10: For window writes, ds_wdata carries h_wdata unchanged, with lanes already placed by the host.
- R11: After reset, ds_valid and h_ready are low and the address register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host request, held until h_ready |
| h_we | input | 1 | Host write (1) or read (0) |
| h_ofs | input | OFS_W | Host byte offset |
| h_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| h_wdata | input | 32 | Host write data, lane-placed |
| h_rdata | output | 32 | Host read data, valid with h_ready |
| h_ready | output | 1 | One-cycle completion pulse |
| ds_valid | output | 1 | Downstream cycle request |
| ds_cmd | output | 3 | Cycle type (0..5, see R2-R4) |
| ds_addr | output | 32 | Downstream target address |
| ds_be | output | 4 | Active-high byte enables |
| ds_wdata | output | 32 | Downstream write data |
| ds_done | input | 1 | Completion of current cycle |
| ds_rdata | input | 32 | Read data, valid with ds_done |
| ds_abort | input | 1 | Completion with no responding target |

## Verification
The bench sweeps every size and low offset through the configuration window at several completion latencies. It checks the lane pattern, the aligned address and the exact ready latency, so a lane map keyed on the wrong offset bit, or an address that leaks bits 1:0, shows up at once. Configuration writes are checked for a guard read with the low byte cleared that lands before the write. A design that skipped the guard, or launched the write first, would produce the wrong first log entry. Aborted reads are compared per window, which exposes a bridge that returns all ones for I/O or forgets it for configuration. Stray offsets are checked by reading the address register back and confirming the downstream log stays empty.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;

   typedef enum logic [2:0] {
      CMD_CFG_RD = 3'd0,
      CMD_CFG_WR = 3'd1,
      CMD_IO_RD  = 3'd2,
      CMD_IO_WR  = 3'd3,
      CMD_MEM_RD = 3'd4,
      CMD_MEM_WR = 3'd5
   } ds_cmd_e;

   typedef enum logic [2:0] {
      WIN_NONE = 3'd0,
      WIN_ADDR = 3'd1,
      WIN_CFG  = 3'd2,
      WIN_IO   = 3'd3,
      WIN_MEM  = 3'd4
   } win_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GUARD = 2'd1,
      ST_XFER  = 2'd2,
      ST_RESP  = 2'd3
   } seq_st_e;

   function automatic ds_cmd_e win_to_cmd(input win_e w, input logic wr);
      ds_cmd_e c;
      case (w)
         WIN_CFG: c = wr ? CMD_CFG_WR : CMD_CFG_RD;
         WIN_IO:  c = wr ? CMD_IO_WR  : CMD_IO_RD;
         default: c = wr ? CMD_MEM_WR : CMD_MEM_RD;
      endcase
      return c;
   endfunction

   function automatic logic cmd_is_read(input ds_cmd_e c);
      return (c == CMD_CFG_RD) || (c == CMD_IO_RD) || (c == CMD_MEM_RD);
   endfunction

endpackage

// File: rtl/cfgio_decode.sv
module cfgio_decode
   import cfgio_pkg::*;
#(
   parameter int          OFS_W      = 12,
   parameter int unsigned OFS_ADDR   = 'h064,
   parameter int unsigned OFS_CFG    = 'h068,
   parameter int unsigned OFS_IO     = 'h06C,
   parameter int unsigned OFS_MEM    = 'h070,
   parameter bit          MEM_WIN_EN = 1'b1
) (
   input  logic [OFS_W-1:0] ofs,
   output win_e             win,
   output logic [1:0]       lane
);

   localparam logic [OFS_W-1:0] A_ADDR = OFS_W'(OFS_ADDR);
   localparam logic [OFS_W-1:0] A_CFG  = OFS_W'(OFS_CFG);
   localparam logic [OFS_W-1:0] A_IO   = OFS_W'(OFS_IO);
   localparam logic [OFS_W-1:0] A_MEM  = OFS_W'(OFS_MEM);

   logic hit_addr, hit_cfg, hit_io, hit_mem;

   assign hit_addr = (ofs[OFS_W-1:2] == A_ADDR[OFS_W-1:2]);
   assign hit_cfg  = (ofs[OFS_W-1:2] == A_CFG[OFS_W-1:2]);
   assign hit_io   = (ofs[OFS_W-1:2] == A_IO[OFS_W-1:2]);

   generate
      if (MEM_WIN_EN) begin : g_mem_win
         assign hit_mem = (ofs[OFS_W-1:2] == A_MEM[OFS_W-1:2]);
      end else begin : g_no_mem_win
         assign hit_mem = 1'b0;
      end
   endgenerate

   always_comb begin
      if (hit_addr)     win = WIN_ADDR;
      else if (hit_cfg) win = WIN_CFG;
      else if (hit_io)  win = WIN_IO;
      else if (hit_mem) win = WIN_MEM;
      else              win = WIN_NONE;
   end

   assign lane = ofs[1:0];

   generate
      if (OFS_W < 8) begin : g_bad_width
         $error("cfgio_decode: OFS_W must be at least 8");
      end
      if ((OFS_ADDR % 4) != 0 || (OFS_CFG % 4) != 0 ||
          (OFS_IO % 4) != 0 || (OFS_MEM % 4) != 0) begin : g_bad_align
         $error("cfgio_decode: register offsets must be word aligned");
      end
      if (OFS_ADDR == OFS_CFG || OFS_ADDR == OFS_IO || OFS_ADDR == OFS_MEM ||
          OFS_CFG == OFS_IO || OFS_CFG == OFS_MEM || OFS_IO == OFS_MEM) begin : g_bad_overlap
         $error("cfgio_decode: register offsets must be distinct");
      end
   endgenerate

   always_comb begin
      AST_ONE_WINDOW: assert ($onehot0({hit_addr, hit_cfg, hit_io, hit_mem})); // R9
   end

endmodule

// File: rtl/cfgio_lanes.sv
module cfgio_lanes #(
   parameter int LANES = 4
) (
   input  logic [1:0]       size,
   input  logic [1:0]       lane,
   output logic [LANES-1:0] be
);

   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("cfgio_lanes: only a four-lane data path is supported");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         localparam logic [1:0] IDX  = 2'(i);
         localparam logic       HALF = IDX[1];
         always_comb begin
            case (size)
               2'd0:    be[i] = (lane == IDX);
               2'd1:    be[i] = (lane[1] == HALF);
               default: be[i] = 1'b1;
            endcase
         end
      end
   endgenerate

   always_comb begin
      AST_LANE_COUNT: assert ($countones(be) == 1 || $countones(be) == 2 ||
                              $countones(be) == 4); // R5
   end

endmodule

// File: rtl/cfgio_seq.sv
module cfgio_seq
   import cfgio_pkg::*;
#(
   parameter bit GUARD_RD = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic h_req,
   input  win_e win,
   input  logic we,
   input  logic ds_done,
   output logic accept,
   output logic guard_act,
   output logic xfer_act,
   output logic finish,
   output logic h_ready
);

   seq_st_e st, st_n;
   logic    needs_guard;
   logic    is_window;

   generate
      if (GUARD_RD) begin : g_guard
         assign needs_guard = (win == WIN_CFG) && we;
      end else begin : g_no_guard
         assign needs_guard = 1'b0;
      end
   endgenerate

   assign is_window = (win == WIN_CFG) || (win == WIN_IO) || (win == WIN_MEM);

   always_comb begin
      st_n   = st;
      accept = 1'b0;
      finish = 1'b0;
      case (st)
         ST_IDLE: begin
            if (h_req) begin
               accept = 1'b1;
               if (is_window) st_n = needs_guard ? ST_GUARD : ST_XFER;
               else           st_n = ST_RESP;
            end
         end
         ST_GUARD: begin
            if (ds_done) st_n = ST_XFER;
         end
         ST_XFER: begin
            if (ds_done) begin
               st_n   = ST_RESP;
               finish = 1'b1;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_n;
   end

   assign guard_act = (st == ST_GUARD);
   assign xfer_act  = (st == ST_XFER);
   assign h_ready   = (st == ST_RESP);

   AST_GUARD_LEADS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      guard_act && ds_done |=> xfer_act); // R6

   AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(h_ready) && !$past(accept) |-> $past(ds_done)); // R7

endmodule

// File: rtl/cfgio_bridge.sv
module cfgio_bridge
   import cfgio_pkg::*;
#(
   parameter int          OFS_W      = 12,
   parameter int          DATA_W     = 32,
   parameter int          IO_W       = 16,
   parameter int unsigned OFS_ADDR   = 'h064,
   parameter int unsigned OFS_CFG    = 'h068,
   parameter int unsigned OFS_IO     = 'h06C,
   parameter int unsigned OFS_MEM    = 'h070,
   parameter bit          MEM_WIN_EN = 1'b1,
   parameter bit          GUARD_RD   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_req,
   input  logic              h_we,
   input  logic [OFS_W-1:0]  h_ofs,
   input  logic [1:0]        h_size,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   output logic              h_ready,
   output logic              ds_valid,
   output logic [2:0]        ds_cmd,
   output logic [31:0]       ds_addr,
   output logic [3:0]        ds_be,
   output logic [DATA_W-1:0] ds_wdata,
   input  logic              ds_done,
   input  logic [DATA_W-1:0] ds_rdata,
   input  logic              ds_abort
);

   localparam int LANES    = DATA_W / 8;
   localparam int GUARD_LO = 8;
   localparam int CFG_LO   = 2;

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("cfgio_bridge: DATA_W must be 32");
      end
      if (IO_W < 2 || IO_W > 32) begin : g_bad_io
         $error("cfgio_bridge: IO_W must lie in 2..32");
      end
   endgenerate

   win_e             win;
   logic [1:0]       lane;
   logic [LANES-1:0] be_live;
   logic             accept, guard_act, xfer_act, finish;

   logic [31:0]       addr_q;
   ds_cmd_e           cmd_q;
   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rd_q;

   cfgio_decode #(
      .OFS_W      (OFS_W),
      .OFS_ADDR   (OFS_ADDR),
      .OFS_CFG    (OFS_CFG),
      .OFS_IO     (OFS_IO),
      .OFS_MEM    (OFS_MEM),
      .MEM_WIN_EN (MEM_WIN_EN)
   ) u_decode (
      .ofs  (h_ofs),
      .win  (win),
      .lane (lane)
   );

   cfgio_lanes #(
      .LANES (LANES)
   ) u_lanes (
      .size (h_size),
      .lane (lane),
      .be   (be_live)
   );

   cfgio_seq #(
      .GUARD_RD (GUARD_RD)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .h_req     (h_req),
      .win       (win),
      .we        (h_we),
      .ds_done   (ds_done),
      .accept    (accept),
      .guard_act (guard_act),
      .xfer_act  (xfer_act),
      .finish    (finish),
      .h_ready   (h_ready)
   );

   // Address register: written lane by lane.
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_addr_lane
         always_ff @(posedge clk) begin
            if (!rst_n)
               addr_q[8*i +: 8] <= '0;
            else if (accept && h_we && (win == WIN_ADDR) && be_live[i])
               addr_q[8*i +: 8] <= h_wdata[8*i +: 8];
         end
      end
   endgenerate

   // Request capture for the downstream cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= CMD_CFG_RD;
         be_q    <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         cmd_q   <= win_to_cmd(win, h_we);
         be_q    <= be_live;
         wdata_q <= h_wdata;
      end
   end

   // Downstream address formation per cycle type.
   logic [31:0] addr_main;
   always_comb begin
      case (cmd_q)
         CMD_CFG_RD, CMD_CFG_WR: addr_main = {addr_q[31:CFG_LO], {CFG_LO{1'b0}}};
         CMD_IO_RD, CMD_IO_WR:   addr_main = 32'(addr_q[IO_W-1:0]);
         default:                addr_main = addr_q;
      endcase
   end

   assign ds_valid = guard_act | xfer_act;
   assign ds_cmd   = guard_act ? CMD_CFG_RD : cmd_q;
   assign ds_addr  = guard_act ? {addr_q[31:GUARD_LO], {GUARD_LO{1'b0}}} : addr_main;
   assign ds_be    = guard_act ? {LANES{1'b1}} : be_q;
   assign ds_wdata = wdata_q;

   // Host read data.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (accept) begin
         rd_q <= ((win == WIN_ADDR) && !h_we) ? addr_q : '0;
      end else if (finish) begin
         if (!cmd_is_read(cmd_q))
            rd_q <= '0;
         else if ((cmd_q == CMD_CFG_RD) && ds_abort)
            rd_q <= '1;
         else
            rd_q <= ds_rdata;
      end
   end

   assign h_rdata = rd_q;

   AST_HOLD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ds_valid && !ds_done |=> ds_valid && $stable(ds_cmd) && $stable(ds_addr) && $stable(ds_be)); // R7

   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      h_ready |=> !h_ready); // R7

   AST_NO_BUS_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      h_ready |-> !ds_valid); // R7

   AST_CFG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      ds_valid && (ds_cmd == CMD_CFG_RD || ds_cmd == CMD_CFG_WR) |-> ds_addr[1:0] == 2'b00); // R2

   AST_IO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ds_valid && (ds_cmd == CMD_IO_RD || ds_cmd == CMD_IO_WR) |-> (ds_addr >> IO_W) == 0); // R3

   AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(h_ready) && $past(ds_done && ds_abort && ds_valid && ds_cmd == CMD_CFG_RD && xfer_act)
      |-> h_rdata == '1); // R8

   generate
      if (GUARD_RD) begin : g_guard_chk
         AST_WRITE_AFTER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ds_valid && ds_cmd == CMD_CFG_WR) |-> $past(ds_done) && $past(ds_addr[7:0]) == 8'h00); // R6
      end
   endgenerate

endmodule

// File: tb/cfgio_bridge_tb.sv
module cfgio_bridge_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        h_req, h_we;
   logic [11:0] h_ofs;
   logic [1:0]  h_size;
   logic [31:0] h_wdata, h_rdata;
   logic        h_ready;
   logic        ds_valid;
   logic [2:0]  ds_cmd;
   logic [31:0] ds_addr;
   logic [3:0]  ds_be;
   logic [31:0] ds_wdata;
   logic        ds_done;
   logic [31:0] ds_rdata;
   logic        ds_abort;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit ended = 0;

   localparam logic [31:0] KEY = 32'h5A5A_0F0F;

   always #5 clk = ~clk;

   cfgio_bridge u_dut (
      .clk(clk), .rst_n(rst_n),
      .h_req(h_req), .h_we(h_we), .h_ofs(h_ofs), .h_size(h_size),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready),
      .ds_valid(ds_valid), .ds_cmd(ds_cmd), .ds_addr(ds_addr), .ds_be(ds_be),
      .ds_wdata(ds_wdata), .ds_done(ds_done), .ds_rdata(ds_rdata), .ds_abort(ds_abort)
   );

   // Downstream responder with transaction log.
   int          lat = 0;
   bit          abort_all = 0;
   int          rcnt = 0;
   int          lg_n = 0;
   logic [2:0]  lg_cmd [0:7];
   logic [31:0] lg_addr[0:7];
   logic [3:0]  lg_be  [0:7];
   logic [31:0] lg_wd  [0:7];

   always @(negedge clk) begin
      if (ds_done) begin
         ds_done = 1'b0;
         rcnt    = 0;
      end else if (ds_valid) begin
         if (rcnt == lat) begin
            ds_done  = 1'b1;
            ds_rdata = ds_addr ^ KEY;
            ds_abort = abort_all;
            if (lg_n < 8) begin
               lg_cmd[lg_n]  = ds_cmd;
               lg_addr[lg_n] = ds_addr;
               lg_be[lg_n]   = ds_be;
               lg_wd[lg_n]   = ds_wdata;
            end
            lg_n++;
         end else begin
            rcnt++;
         end
      end
   end

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog: run hung (actual cycles=%0d expected < 150000)", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hx(input logic we, input logic [11:0] ofs, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output int waits);
      lg_n = 0;
      @(negedge clk);
      h_req = 1'b1; h_we = we; h_ofs = ofs; h_size = sz; h_wdata = wd;
      waits = 0;
      do begin
         @(negedge clk);
         waits++;
      end while (!h_ready);
      rd    = h_rdata;
      h_req = 1'b0;
   endtask

   function automatic logic [3:0] exp_be(input int sz, input int off);
      if (sz == 0) return 4'b0001 << off;
      if (sz == 1) return 4'b0011 << (off & 2);
      return 4'b1111;
   endfunction

   logic [31:0] rd;
   int          w;

   initial begin
      rst_n = 1'b0; h_req = 1'b0; h_we = 1'b0; h_ofs = '0; h_size = 2'd2; h_wdata = '0;
      ds_done = 1'b0; ds_rdata = '0; ds_abort = 1'b0;
      repeat (4) @(negedge clk);
      // R11: reset state
      chk(!ds_valid, "R11 ds_valid", 32'(ds_valid), 0);
      chk(!h_ready, "R11 h_ready", 32'(h_ready), 0);
      rst_n = 1'b1;
      hx(0, 12'h064, 2, 0, rd, w);
      chk(rd == 0, "R11 addr reg after reset", rd, 0);

      // R1: full write, readback, ready latency, no bus cycle
      hx(1, 12'h064, 2, 32'h1234_5678, rd, w);
      chk(w == 1, "R1 write ready latency", w, 1);
      hx(0, 12'h064, 2, 0, rd, w);
      chk(rd == 32'h1234_5678, "R1 readback", rd, 32'h1234_5678);
      chk(lg_n == 0, "R1 no downstream cycle", lg_n, 0);
      // R1: byte-lane write into lane 1
      hx(1, 12'h065, 0, 32'h0000_AB00, rd, w);
      hx(0, 12'h064, 2, 0, rd, w);
      chk(rd == 32'h1234_AB78, "R1 byte lane write", rd, 32'h1234_AB78);
      // R1: halfword write to upper half
      hx(1, 12'h066, 1, 32'hCAFE_0000, rd, w);
      hx(0, 12'h064, 2, 0, rd, w);
      chk(rd == 32'hCAFE_AB78, "R1 half lane write", rd, 32'hCAFE_AB78);

      // R2/R5/R7: config read sweep
      hx(1, 12'h064, 2, 32'h0003_2847, rd, w);
      for (int l = 0; l < 3; l++) begin
         lat = l;
         for (int s = 0; s < 3; s++) begin
            for (int o = 0; o < 4; o++) begin
               hx(0, 12'h068 + 12'(o), 2'(s), 0, rd, w);
               chk(lg_n == 1, "R2 one cycle", lg_n, 1);
               chk(lg_cmd[0] == 3'd0, "R2 cfg read cmd", 32'(lg_cmd[0]), 0);
               chk(lg_addr[0] == 32'h0003_2844, "R2 cfg addr", lg_addr[0], 32'h0003_2844);
               chk(lg_be[0] == exp_be(s, o), "R5 byte enables", 32'(lg_be[0]), 32'(exp_be(s, o)));
               chk(rd == (32'h0003_2844 ^ KEY), "R8 read data", rd, 32'h0003_2844 ^ KEY);
               chk(w == l + 2, "R7 ready latency", w, l + 2);
            end
         end
      end

      // R6/R10/R5: config write sweep with guard
      lat = 1;
      for (int s = 0; s < 4; s++) begin
         for (int o = 0; o < 4; o++) begin
            logic [31:0] d;
            d = 32'hA000_0000 + 32'(s * 16 + o);
            hx(1, 12'h068 + 12'(o), 2'(s), d, rd, w);
            chk(lg_n == 2, "R6 guard plus write", lg_n, 2);
            chk(lg_cmd[0] == 3'd0, "R6 guard cmd", 32'(lg_cmd[0]), 0);
            chk(lg_addr[0] == 32'h0003_2800, "R6 guard addr", lg_addr[0], 32'h0003_2800);
            chk(lg_be[0] == 4'hF, "R6 guard be", 32'(lg_be[0]), 32'hF);
            chk(lg_cmd[1] == 3'd1, "R2 cfg write cmd", 32'(lg_cmd[1]), 1);
            chk(lg_addr[1] == 32'h0003_2844, "R2 cfg write addr", lg_addr[1], 32'h0003_2844);
            chk(lg_be[1] == exp_be(s > 2 ? 2 : s, o), "R5 write be", 32'(lg_be[1]),
                32'(exp_be(s > 2 ? 2 : s, o)));
            chk(lg_wd[1] == d, "R10 write data", lg_wd[1], d);
         end
      end

      // R3: I/O window
      lat = 0;
      hx(1, 12'h064, 2, 32'hBEEF_1235, rd, w);
      hx(0, 12'h06D, 0, 0, rd, w);
      chk(lg_n == 1 && lg_cmd[0] == 3'd2, "R3 io read cmd", 32'(lg_cmd[0]), 2);
      chk(lg_addr[0] == 32'h0000_1235, "R3 io addr", lg_addr[0], 32'h0000_1235);
      chk(lg_be[0] == 4'b0010, "R5 io byte be", 32'(lg_be[0]), 32'h2);
      chk(rd == (32'h0000_1235 ^ KEY), "R3 io read data", rd, 32'h0000_1235 ^ KEY);
      hx(1, 12'h06E, 1, 32'h7788_0000, rd, w);
      chk(lg_n == 1 && lg_cmd[0] == 3'd3, "R3 io write cmd, no guard", 32'(lg_cmd[0]), 3);
      chk(lg_wd[0] == 32'h7788_0000, "R10 io write data", lg_wd[0], 32'h7788_0000);

      // R4: memory window
      hx(0, 12'h070, 2, 0, rd, w);
      chk(lg_n == 1 && lg_cmd[0] == 3'd4, "R4 mem read cmd", 32'(lg_cmd[0]), 4);
      chk(lg_addr[0] == 32'hBEEF_1235, "R4 mem addr", lg_addr[0], 32'hBEEF_1235);
      hx(1, 12'h073, 0, 32'h5500_0000, rd, w);
      chk(lg_n == 1 && lg_cmd[0] == 3'd5, "R4 mem write cmd", 32'(lg_cmd[0]), 5);
      chk(lg_be[0] == 4'b1000, "R5 mem byte be", 32'(lg_be[0]), 32'h8);

      // R8: aborts
      abort_all = 1;
      hx(1, 12'h064, 2, 32'h00EE_1000, rd, w);
      hx(0, 12'h068, 2, 0, rd, w);
      chk(rd == 32'hFFFF_FFFF, "R8 cfg abort all ones", rd, 32'hFFFF_FFFF);
      hx(0, 12'h06C, 2, 0, rd, w);
      chk(rd == (32'h0000_1000 ^ KEY), "R8 io abort raw data", rd, 32'h0000_1000 ^ KEY);
      abort_all = 0;
      hx(0, 12'h068, 2, 0, rd, w);
      chk(rd == (32'h00EE_1000 ^ KEY), "R8 cfg normal data", rd, 32'h00EE_1000 ^ KEY);

      // R9: unmapped offsets
      for (int k = 0; k < 3; k++) begin
         logic [11:0] bo;
         bo = (k == 0) ? 12'h060 : (k == 1) ? 12'h074 : 12'h0A4;
         hx(1, bo, 2, 32'hDEAD_BEEF, rd, w);
         chk(lg_n == 0, "R9 write no cycle", lg_n, 0);
         hx(0, bo, 2, 0, rd, w);
         chk(rd == 0 && lg_n == 0, "R9 read zero", rd, 0);
         hx(0, 12'h064, 2, 0, rd, w);
         chk(rd == 32'h00EE_1000, "R9 addr reg unchanged", rd, 32'h00EE_1000);
      end

      repeat (3) @(negedge clk);
      summary();
   end

endmodule